// File: doc/BRIEF.md
# Dual Clock-Configuration Register with Override

This block is a memory-mapped clock-configuration unit. It holds two 32-bit registers: a legacy configuration word and an extended configuration word. A use-extended bit in the extended word chooses which word's fields drive the clock controls. The block outputs the effective oscillator source, bypass, PLL power-down and system divisor. The extended fields sit at the same least-significant bit positions as their legacy counterparts, but some of them are wider.

The clock path is modelled as enable pulses. The block divides the selected PLL reference enable by the effective divisor plus one to produce a system clock-enable pulse. When bypass or power-down is active, the oscillator reference enable passes straight to the output.

A divide-by-400 mode bit appends one extra low bit to the extended divisor. This forms a 7-bit divisor, which is applied to the undivided (fast) PLL enable. A plain register bus gives access to both words: address, write strobe, write data and combinational read data. A sticky error flag marks an extended write that follows a legacy write with no access in between.

Top module: `clk_cfg_unit`

## Requirements
- R1: After reset, reads return 0x07802810 at offset 0x060 (legacy) and 0x07C02810 at offset 0x070 (extended). The effective outputs at reset are oscillator source 1, bypass 1, power-down 1 and divisor 15.
- R2: While extended bit 31 is 0, the legacy fields drive the outputs and every extended field is ignored. The legacy fields are: oscillator source at bits 5:4 (zero-extended to 3 bits), bypass at bit 11, power-down at bit 13, and divisor at bits 26:23 (zero-extended to 7 bits).
- R3: While extended bit 31 is 1, the extended fields drive the outputs. These are oscillator source at bits 6:4, bypass at bit 11 and power-down at bit 13.
- R4: With bit 31 set and extended bit 30 at 0, the divisor is bits 28:23, zero-extended, and the predivided reference enable is used. With bit 30 at 1, the divisor is {bits 28:23, bit 22} and the fast reference enable is used.
- R5: Only bits 26:23, 13, 11 and 5:4 of the legacy word are stored. Only bits 31, 30, 28:22, 13, 11 and 6:4 of the extended word are stored. All other bits read as 0. Reads of any other offset return 0, and writes to any other offset change nothing.
- R6: While not held, the system enable pulses on the selected reference enable that completes each group of divisor+1 reference enables. A divisor of 0 passes every reference enable.
- R7: In the cycle when the effective divisor changes, the system enable is 0 and the count restarts from zero.
- R8: While effective bypass or power-down is 1, the system enable equals the oscillator enable and the count stays at zero.
- R9: A register write takes effect on the outputs and the read data in the cycle after the write strobe.
- R10: An extended write in the cycle right after a legacy write sets the ordering-error output. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pll_en_i | input | 1 | Predivided PLL reference enable |
| pll_fast_en_i | input | 1 | Undivided PLL reference enable |
| osc_en_i | input | 1 | Oscillator reference enable |
| osc_src_o | output | 3 | Effective oscillator source |
| bypass_o | output | 1 | Effective bypass |
| pwrdn_o | output | 1 | Effective PLL power-down |
| sys_div_o | output | 7 | Effective divisor field value |
| sys_en_o | output | 1 | System clock-enable pulse |
| order_err_o | output | 1 | Sticky write-ordering error |

## Verification
Every clock cycle, the bench compares all outputs and the read data against a behavioural model. The three reference enables run as independent pseudo-random streams. Selecting a source therefore shows up as a mismatch if the wrong stream is used.

The legacy word is first driven with mixed field values while the extended word holds different values but is not in use. This separates R2 from R3. The extended word is then run with divide-by-400 mode off and on, using different low-bit values. This tells apart the 6-bit and 7-bit divisor forms and the two PLL enables. Divisor 0, mid-run divisor changes, bypass, power-down and all-ones writes cover the pass-through, reload and masking cases. A legacy write followed directly by an extended write, compared with the same pair separated by a read, tells the ordering flag's trigger apart from a harmless sequence.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 7;
  localparam int SRC_W  = 3;

  localparam logic [DATA_W-1:0] LEG_MASK = 32'h0780_2830;
  localparam logic [DATA_W-1:0] LEG_RST  = 32'h0780_2810;
  localparam logic [DATA_W-1:0] EXT_MASK = 32'hDFC0_2870;
  localparam logic [DATA_W-1:0] EXT_RST  = 32'h07C0_2810;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             bypass;
    logic             pwrdn;
    logic [DIV_W-1:0] div;
    logic             fast_ref;
  } clk_sel_t;
endpackage

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs
  import clk_cfg_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] LEG_OFFS = 'h060,
  parameter logic [ADDR_W-1:0] EXT_OFFS = 'h070
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] leg_o,
  output logic [DATA_W-1:0] ext_o,
  output logic              order_err_o
);
  logic [DATA_W-1:0] leg_q, ext_q;
  logic leg_wr, ext_wr, leg_wr_q, err_q;

  assign leg_wr = we_i && (addr_i == LEG_OFFS);
  assign ext_wr = we_i && (addr_i == EXT_OFFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q    <= LEG_RST;
      ext_q    <= EXT_RST;
      leg_wr_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (leg_wr) leg_q <= wdata_i & LEG_MASK;
      if (ext_wr) ext_q <= wdata_i & EXT_MASK;
      leg_wr_q <= leg_wr;
      // back-to-back legacy then extended write violates ordering rule
      if (ext_wr && leg_wr_q) err_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == LEG_OFFS)      rdata_o = leg_q;
    else if (addr_i == EXT_OFFS) rdata_o = ext_q;
  end

  assign leg_o       = leg_q;
  assign ext_o       = ext_q;
  assign order_err_o = err_q;

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_err_o |=> order_err_o);
  a_r10_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leg_wr_q && ext_wr) |=> order_err_o);
  a_r5_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((leg_q & ~LEG_MASK) == '0) && ((ext_q & ~EXT_MASK) == '0));
  a_r9_leg_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_wr |=> (leg_o == ($past(wdata_i) & LEG_MASK)));
endmodule

// File: rtl/clk_cfg_select.sv
module clk_cfg_select
  import clk_cfg_pkg::*;
(
  input  logic [DATA_W-1:0] leg_i,
  input  logic [DATA_W-1:0] ext_i,
  output clk_sel_t          sel_o
);
  logic use_ext, div400;
  assign use_ext = ext_i[31];
  assign div400  = ext_i[30];

  always_comb begin
    if (use_ext) begin
      sel_o.src      = ext_i[6:4];
      sel_o.bypass   = ext_i[11];
      sel_o.pwrdn    = ext_i[13];
      sel_o.div      = div400 ? ext_i[28:22] : {1'b0, ext_i[28:23]};
      sel_o.fast_ref = div400;
    end else begin
      sel_o.src      = {1'b0, leg_i[5:4]};
      sel_o.bypass   = leg_i[11];
      sel_o.pwrdn    = leg_i[13];
      sel_o.div      = {3'b000, leg_i[26:23]};
      sel_o.fast_ref = 1'b0;
    end
  end

  always_comb begin
    if (!use_ext) a_r2_narrow_div: assert (sel_o.div[DIV_W-1:4] == '0);
  end
endmodule

// File: rtl/clk_cfg_divider.sv
module clk_cfg_divider #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ref_en_i,
  input  logic             osc_en_i,
  input  logic             hold_i,
  output logic             sys_en_o
);
  logic [DIV_W-1:0] cnt_q, div_q;
  logic div_chg, terminal;

  assign div_chg  = (div_i != div_q);
  assign terminal = ref_en_i && (cnt_q == div_i) && !div_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      div_q <= div_i;
      if (hold_i || div_chg) cnt_q <= '0;
      else if (terminal)     cnt_q <= '0;
      else if (ref_en_i)     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sys_en_o = hold_i ? osc_en_i : terminal;

  a_r8_cnt_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i != div_q) |=> (cnt_q == '0));
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i && (div_i == div_q) |-> (cnt_q <= div_i));
  a_r6_sparse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_en_o && !hold_i && (div_i != '0)) |=> (!sys_en_o || hold_i));
endmodule

// File: rtl/clk_cfg_unit.sv
module clk_cfg_unit
  import clk_cfg_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] LEG_OFFS = 'h060,
  parameter logic [ADDR_W-1:0] EXT_OFFS = 'h070
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              pll_en_i,
  input  logic              pll_fast_en_i,
  input  logic              osc_en_i,
  output logic [SRC_W-1:0]  osc_src_o,
  output logic              bypass_o,
  output logic              pwrdn_o,
  output logic [DIV_W-1:0]  sys_div_o,
  output logic              sys_en_o,
  output logic              order_err_o
);
  logic [DATA_W-1:0] leg_w, ext_w;
  clk_sel_t sel;
  logic ref_en, hold;

  clk_cfg_regs #(.ADDR_W(ADDR_W), .LEG_OFFS(LEG_OFFS), .EXT_OFFS(EXT_OFFS)) u_regs (
    .clk_i, .rst_ni, .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .leg_o(leg_w), .ext_o(ext_w), .order_err_o
  );

  clk_cfg_select u_sel (.leg_i(leg_w), .ext_i(ext_w), .sel_o(sel));

  assign ref_en = sel.fast_ref ? pll_fast_en_i : pll_en_i;
  assign hold   = sel.bypass | sel.pwrdn;

  clk_cfg_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .div_i(sel.div), .ref_en_i(ref_en), .osc_en_i,
    .hold_i(hold), .sys_en_o
  );

  assign osc_src_o = sel.src;
  assign bypass_o  = sel.bypass;
  assign pwrdn_o   = sel.pwrdn;
  assign sys_div_o = sel.div;
endmodule

// File: tb/clk_cfg_unit_tb.sv
`timescale 1ns/1ps
module clk_cfg_unit_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic pll_en = 1'b0, fast_en = 1'b0, osc_en = 1'b0;
  logic [2:0] src;
  logic byp, pd, sys_en, err;
  logic [6:0] div;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_leg = 32'h0780_2810, m_ext = 32'h07C0_2810;
  int m_cnt = 0, m_pdiv = 0;
  bit m_plw = 0, m_err = 0, m_pwe = 0;

  always #4 clk = ~clk;

  clk_cfg_unit u_dut (
    .clk_i(clk), .rst_ni, .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pll_en_i(pll_en), .pll_fast_en_i(fast_en), .osc_en_i(osc_en),
    .osc_src_o(src), .bypass_o(byp), .pwrdn_o(pd), .sys_div_o(div),
    .sys_en_o(sys_en), .order_err_o(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model at posedge
  task automatic cyc(bit w, logic [11:0] a, logic [31:0] d, bit first = 0);
    bit use_x, d4, ref_e, hold;
    int e_div;
    logic [2:0] e_src;
    logic e_byp, e_pd, e_en;
    logic [31:0] e_rd;
    we = w; addr = a; wdata = d;
    pll_en = ($urandom % 3) != 0; fast_en = ($urandom % 2) != 0; osc_en = ($urandom % 4) == 0;
    #1;
    use_x = m_ext[31]; d4 = m_ext[30];
    if (use_x) begin
      e_src = m_ext[6:4]; e_byp = m_ext[11]; e_pd = m_ext[13];
      e_div = d4 ? int'(m_ext[28:22]) : int'(m_ext[28:23]);
    end else begin
      e_src = {1'b0, m_leg[5:4]}; e_byp = m_leg[11]; e_pd = m_leg[13];
      e_div = int'(m_leg[26:23]);
    end
    ref_e = (use_x && d4) ? fast_en : pll_en;
    hold = e_byp || e_pd;
    e_en = hold ? osc_en : (e_div == m_pdiv && ref_e && m_cnt == e_div);
    e_rd = (a == 12'h060) ? m_leg : (a == 12'h070) ? m_ext : 32'h0;
    chk(first ? "R1 src" : use_x ? "R3 src" : "R2 src", 32'(src), 32'(e_src));
    chk(first ? "R1 bypass" : use_x ? "R3 bypass" : "R2 bypass", 32'(byp), 32'(e_byp));
    chk(first ? "R1 pwrdn" : use_x ? "R3 pwrdn" : "R2 pwrdn", 32'(pd), 32'(e_pd));
    chk(use_x ? "R4 divisor" : "R2 divisor", 32'(div), 32'(e_div));
    chk(first ? "R1 rdata" : m_pwe ? "R9 rdata" : "R5 rdata", rdata, e_rd);
    chk(hold ? "R8 sys_en" : (e_div != m_pdiv) ? "R7 sys_en" : "R6 sys_en", 32'(sys_en), 32'(e_en));
    chk("R10 order_err", 32'(err), 32'(m_err));
    @(posedge clk);
    if (hold || e_div != m_pdiv) m_cnt = 0;
    else if (ref_e) m_cnt = (m_cnt == e_div) ? 0 : m_cnt + 1;
    m_pdiv = e_div;
    if (w && a == 12'h070 && m_plw) m_err = 1;
    m_plw = w && (a == 12'h060);
    m_pwe = w;
    if (w && a == 12'h060) m_leg = d & 32'h0780_2830;
    if (w && a == 12'h070) m_ext = d & 32'hDFC0_2870;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a); cyc(0, a, 32'h0); endtask
  task automatic run(int n, logic [11:0] a);
    for (int i = 0; i < n; i++) rd(a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset readback
    cyc(0, 12'h060, 0, 1);
    cyc(0, 12'h070, 0, 1);
    rd(12'h064); rd(12'hFFC);
    // R2 legacy drive: div 3, osc 2, run; junk bits test R5
    cyc(1, 12'h060, 32'hF8FF_D7E1 & ~32'h0780_2830 | 32'h0180_0020);
    run(40, 12'h060);
    // extended fields loaded but unused -> ignored (R2)
    cyc(1, 12'h070, 32'h5F80_2050);
    run(30, 12'h070);
    // R3/R4 extended, 6-bit divisor 5, predivided ref
    cyc(1, 12'h070, 32'h8280_0060);
    run(40, 12'h070);
    // R4 7-bit divisor {2,1}=5 on fast ref
    cyc(1, 12'h070, 32'hC140_0020);
    run(40, 12'h070);
    // R7 divisor change mid-run, then divisor 0 (R6)
    cyc(1, 12'h070, 32'hC0C0_0020);
    run(20, 12'h070);
    cyc(1, 12'h070, 32'hC000_0020);
    run(20, 12'h070);
    // R8 bypass and power-down via extended
    cyc(1, 12'h070, 32'h8100_0810);
    run(20, 12'h070);
    cyc(1, 12'h070, 32'h8100_2010);
    run(20, 12'h070);
    // R5 all-ones write, write to unmapped offset
    cyc(1, 12'h070, 32'hFFFF_FFFF);
    run(10, 12'h070);
    cyc(1, 12'h068, 32'hFFFF_FFFF);
    rd(12'h068); rd(12'h060); rd(12'h070);
    // back to legacy; legacy then read then extended: no error (R10)
    cyc(1, 12'h060, 32'hFFFF_FFFF);
    rd(12'h060);
    cyc(1, 12'h070, 32'h0000_0000);
    run(30, 12'h060);
    // R10 legacy directly followed by extended: sticky error
    cyc(1, 12'h060, 32'h0100_0010);
    cyc(1, 12'h070, 32'h0000_0000);
    run(20, 12'h060);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all-reqs act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule